// File: doc/BRIEF.md
# Mode Latch and Power-Down Controller

This block owns the global operating state of an audio sub-band coding processor. It filters a system reset request and a codec reset request so that only pulses lasting a minimum number of processing-clock periods have any effect. A qualified system reset forces decode mode. A qualified codec reset latches the direction input at the moment the reset falls: a 1 selects decode (feed-through) and a 0 selects encode (calculation). The block also decodes two resolution-select pins into an input sample width and passes on an allocate-all policy flag for the allocator downstream.

A power-down request puts the block to sleep. While asleep it withdraws the drive enable of every 3-state pin and raises a hold signal that freezes the normal outputs. Lowering the power-down input does not end sleep. Only a qualified system reset wakes the block. All request inputs pass through a two-flop synchroniser before any pulse-width counting.

Top module: `mode_sleep_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, the outputs are `mode_decode`=1, `res_bits`=16, `alloc_all`=0, `tri_en`=1 and `hold`=0.
- R2: A system reset request (`sys_rst_req` HIGH) is accepted only if it stays HIGH for at least MIN_PULSE (default 5) consecutive clock edges. An accepted request sets `mode_decode`=1. A shorter pulse changes nothing.
- R3: A codec reset (`codec_rst_req`) that was HIGH for at least MIN_PULSE edges and then falls latches `dir_sel`, as it stood in the last HIGH cycle, into `mode_decode`. The value 1 means decode and 0 means encode.
- R4: A codec reset shorter than MIN_PULSE edges leaves `mode_decode` unchanged.
- R5: `res_sel[1:0]` decodes as 00→16, 01→18, 10→14 and 11→15 bits on `res_bits`, so `res_bits` only ever takes one of those four values.
- R6: `alloc_all` follows the `alloc_all_pin` input: 1 distributes the whole bit pool, 0 gives no bits to sub-bands below the resolution threshold.
- R7: While awake, a HIGH `pwr_down_req` makes the block enter sleep, with `tri_en`=0 and `hold`=1.
- R8: While asleep, `mode_decode`, `res_bits` and `alloc_all` hold their values, whatever happens on `res_sel`, `alloc_all_pin`, `dir_sel` or `codec_rst_req`.
- R9: Sleep ends only on an accepted system reset, which restores `tri_en`=1, `hold`=0 and `mode_decode`=1. Lowering `pwr_down_req` and short system reset pulses do not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous active-low local reset |
| sys_rst_req | input | 1 | System reset request, active HIGH, asynchronous |
| codec_rst_req | input | 1 | Codec reset request, active HIGH, asynchronous |
| dir_sel | input | 1 | Direction input, sampled when the codec reset falls |
| pwr_down_req | input | 1 | Power-down request, active HIGH |
| res_sel | input | 2 | Resolution-select pins, quasi-static |
| alloc_all_pin | input | 1 | Allocate-all policy pin, quasi-static |
| mode_decode | output | 1 | 1 = decode (feed-through), 0 = encode (calculation) |
| res_bits | output | 5 | Decoded input sample width in bits |
| alloc_all | output | 1 | Allocation policy flag |
| tri_en | output | 1 | Drive enable for all 3-state pins |
| hold | output | 1 | Freezes the normal outputs during sleep |

## Verification
The assertions check on every cycle that `res_bits` stays inside its four legal values, that the frozen outputs do not move while asleep, and that the mode changes only after an accepted reset event. They also check that a synchronised power-down request leads to sleep on the next edge, and that sleep ends only after an accepted system reset. The scenarios are needed to show the pulse-width boundary: four edges are ignored and five are accepted, for both reset requests. They also show which value of `dir_sel` is latched, the full resolution table, and that lowering the power-down input alone does not wake the block.

// File: rtl/msc_pkg.sv
// Package: shared types and the resolution table for the mode/sleep controller.
// Assumes: the resolution pins use a fixed 2-bit encoding.
package msc_pkg;

    localparam int RES_W = 5;

    typedef enum logic {
        PS_AWAKE  = 1'b0,
        PS_ASLEEP = 1'b1
    } pwr_state_e;

    // Map resolution-select code to sample width in bits.
    function automatic logic [RES_W-1:0] res_lookup(input logic [1:0] code);
        logic [RES_W-1:0] w;
        case (code)
            2'b00:   w = RES_W'(16);
            2'b01:   w = RES_W'(18);
            2'b10:   w = RES_W'(14);
            default: w = RES_W'(15);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/msc_sync.sv
// Module: msc_sync
// Multi-stage flop synchroniser for a bundle of independent single-bit inputs.
// Assumes: each bit is its own asynchronous signal; bits are not a coherent bus.
module msc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/msc_pulse_qual.sv
// Module: msc_pulse_qual
// Counts consecutive HIGH cycles of a synchronised request. It emits a
// one-cycle event either when the count first reaches MIN_PULSE (ON_FALL=0)
// or when a pulse of at least MIN_PULSE cycles ends (ON_FALL=1).
// Assumes: the input is already synchronous to clk.
module msc_pulse_qual #(
    parameter int MIN_PULSE = 5,
    parameter bit ON_FALL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic event_o
);

    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(MIN_PULSE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Saturating count of consecutive HIGH cycles; cleared by a LOW cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!req_s)     cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    if (ON_FALL) begin : g_fall
        logic req_d;

        // Previous request level for falling-edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) req_d <= 1'b0;
            else        req_d <= req_s;
        end

        assign event_o = req_d && !req_s && (cnt_q == CNT_MAX);
    end else begin : g_rise
        assign event_o = req_s && (cnt_q == CNT_HIT);
    end

endmodule

// File: rtl/msc_mode_latch.sv
// Module: msc_mode_latch
// Holds the encode/decode mode. An accepted system reset forces decode. An
// accepted codec-reset fall loads the direction value from the last HIGH cycle.
// Assumes: events are single-cycle; freeze comes from the sleep controller.
module msc_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_hit,
    input  logic codec_ok,
    input  logic dir_s,
    input  logic freeze,
    output logic mode_decode
);

    logic dir_d;

    // Delay direction by one cycle so it lines up with the last HIGH cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_d <= 1'b1;
        else        dir_d <= dir_s;
    end

    // Mode register: system reset wins, codec event ignored while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mode_decode <= 1'b1;
        else if (sys_hit)             mode_decode <= 1'b1;
        else if (codec_ok && !freeze) mode_decode <= dir_d;
    end

endmodule

// File: rtl/msc_sleep_fsm.sv
// Module: msc_sleep_fsm
// Two-state power controller. It enters sleep on a power-down request and
// leaves only on an accepted system reset.
// Assumes: pwr_s is synchronised; sys_hit is a single-cycle event.
module msc_sleep_fsm
    import msc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_s,
    input  logic sys_hit,
    output logic tri_en,
    output logic hold
);

    pwr_state_e state_q, state_d;

    // Next-state logic: reset event has priority over sleep entry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_AWAKE:  if (!sys_hit && pwr_s) state_d = PS_ASLEEP;
            PS_ASLEEP: if (sys_hit)           state_d = PS_AWAKE;
            default:                          state_d = PS_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_AWAKE;
        else        state_q <= state_d;
    end

    assign tri_en = (state_q == PS_AWAKE);
    assign hold   = (state_q == PS_ASLEEP);

endmodule

// File: rtl/msc_cfg_regs.sv
// Module: msc_cfg_regs
// Registers the decoded resolution and allocation policy, frozen during hold.
// Assumes: res_sel and alloc pin are quasi-static board straps, one flop is enough.
module msc_cfg_regs
    import msc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic [1:0]       res_sel,
    input  logic             alloc_pin,
    output logic [RES_W-1:0] res_bits,
    output logic             alloc_all
);

    // Capture the decoded configuration unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_bits  <= res_lookup(2'b00);
            alloc_all <= 1'b0;
        end else if (!freeze) begin
            res_bits  <= res_lookup(res_sel);
            alloc_all <= alloc_pin;
        end
    end

endmodule

// File: rtl/mode_sleep_ctrl.sv
// Module: mode_sleep_ctrl (top)
// Qualifies the reset requests, latches the operating mode, decodes the
// resolution straps and runs the sleep controller that floats the 3-state
// pins and freezes the normal outputs.
// Assumes: rst_n is synchronous to clk; the request inputs may be asynchronous.
module mode_sleep_ctrl
    import msc_pkg::*;
#(
    parameter int MIN_PULSE   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst_req,
    input  logic             codec_rst_req,
    input  logic             dir_sel,
    input  logic             pwr_down_req,
    input  logic [1:0]       res_sel,
    input  logic             alloc_all_pin,
    output logic             mode_decode,
    output logic [RES_W-1:0] res_bits,
    output logic             alloc_all,
    output logic             tri_en,
    output logic             hold
);

    localparam int N_SYNC = 4;

    logic [N_SYNC-1:0] raw_in, sync_q;
    logic sys_s, codec_s, dir_s, pwr_s;
    logic sys_hit, codec_ok;

    assign raw_in = {pwr_down_req, dir_sel, codec_rst_req, sys_rst_req};
    assign {pwr_s, dir_s, codec_s, sys_s} = sync_q;

    msc_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
    );

    msc_pulse_qual #(.MIN_PULSE(MIN_PULSE), .ON_FALL(1'b0)) u_sys_qual (
        .clk(clk), .rst_n(rst_n), .req_s(sys_s), .event_o(sys_hit)
    );

    msc_pulse_qual #(.MIN_PULSE(MIN_PULSE), .ON_FALL(1'b1)) u_codec_qual (
        .clk(clk), .rst_n(rst_n), .req_s(codec_s), .event_o(codec_ok)
    );

    msc_sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_s(pwr_s), .sys_hit(sys_hit),
        .tri_en(tri_en), .hold(hold)
    );

    msc_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .sys_hit(sys_hit), .codec_ok(codec_ok),
        .dir_s(dir_s), .freeze(hold), .mode_decode(mode_decode)
    );

    msc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .freeze(hold), .res_sel(res_sel),
        .alloc_pin(alloc_all_pin), .res_bits(res_bits), .alloc_all(alloc_all)
    );

endmodule

// File: rtl/mode_sleep_ctrl_chk.sv
// Module: mode_sleep_ctrl_chk
// Property checker bound into mode_sleep_ctrl.
// Assumes: it sees the internal event and synchroniser signals through the bind.
module mode_sleep_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_hit,
    input logic       codec_ok,
    input logic       pwr_s,
    input logic       mode_decode,
    input logic [4:0] res_bits,
    input logic       alloc_all,
    input logic       hold
);

    // R5
    res_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_bits == 5'd14) || (res_bits == 5'd15) ||
        (res_bits == 5'd16) || (res_bits == 5'd18));

    // R2
    sys_forces_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_hit |=> mode_decode);

    // R4
    mode_only_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_decode) |-> $past(sys_hit || codec_ok));

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && pwr_s && !sys_hit) |=> hold);

    // R8
    frozen_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |->
        ($stable(mode_decode) && $stable(res_bits) && $stable(alloc_all)));

    // R9
    wake_by_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(sys_hit));

endmodule

bind mode_sleep_ctrl mode_sleep_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sys_hit(sys_hit), .codec_ok(codec_ok),
    .pwr_s(pwr_s), .mode_decode(mode_decode), .res_bits(res_bits),
    .alloc_all(alloc_all), .hold(hold)
);

// File: tb/mode_sleep_ctrl_tb.sv
module mode_sleep_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rst_req = 1'b0;
    logic       codec_rst_req = 1'b0;
    logic       dir_sel = 1'b1;
    logic       pwr_down_req = 1'b0;
    logic [1:0] res_sel = 2'b00;
    logic       alloc_all_pin = 1'b0;
    logic       mode_decode, alloc_all, tri_en, hold;
    logic [4:0] res_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mode_sleep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req),
        .codec_rst_req(codec_rst_req), .dir_sel(dir_sel),
        .pwr_down_req(pwr_down_req), .res_sel(res_sel),
        .alloc_all_pin(alloc_all_pin), .mode_decode(mode_decode),
        .res_bits(res_bits), .alloc_all(alloc_all), .tri_en(tri_en),
        .hold(hold)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold system reset HIGH for n rising edges, then let it settle.
    task automatic pulse_sys(input int n);
        @(negedge clk) sys_rst_req = 1'b1;
        idle(n);
        sys_rst_req = 1'b0;
        idle(8);
    endtask

    // Hold codec reset HIGH for n rising edges with direction d.
    task automatic pulse_codec(input int n, input logic d);
        @(negedge clk) begin dir_sel = d; codec_rst_req = 1'b1; end
        idle(n);
        codec_rst_req = 1'b0;
        idle(8);
    endtask

    task automatic t_reset_state;
        chk("R1 mode_decode", mode_decode, 1);
        chk("R1 res_bits", res_bits, 16);
        chk("R1 alloc_all", alloc_all, 0);
        chk("R1 tri_en", tri_en, 1);
        chk("R1 hold", hold, 0);
    endtask

    task automatic t_codec_modes;
        pulse_codec(5, 1'b0);
        chk("R3 encode latched", mode_decode, 0);
        pulse_codec(7, 1'b1);
        chk("R3 decode latched", mode_decode, 1);
        pulse_codec(5, 1'b0);
        chk("R3 encode again", mode_decode, 0);
    endtask

    task automatic t_codec_short;
        pulse_codec(4, 1'b1);
        chk("R4 short codec ignored", mode_decode, 0);
        pulse_codec(1, 1'b1);
        chk("R4 one-cycle codec ignored", mode_decode, 0);
    endtask

    task automatic t_sys_reset;
        pulse_sys(4);
        chk("R2 short sys reset ignored", mode_decode, 0);
        pulse_sys(5);
        chk("R2 sys reset forces decode", mode_decode, 1);
        chk("R2 awake after sys reset", tri_en, 1);
    endtask

    task automatic t_res_table;
        logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
        int exp_w [4] = '{16, 18, 14, 15};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) res_sel = codes[i];
            idle(2);
            chk("R5 res_bits", res_bits, exp_w[i]);
        end
    endtask

    task automatic t_alloc;
        @(negedge clk) alloc_all_pin = 1'b1;
        idle(2);
        chk("R6 alloc high", alloc_all, 1);
        @(negedge clk) alloc_all_pin = 1'b0;
        idle(2);
        chk("R6 alloc low", alloc_all, 0);
    endtask

    task automatic t_sleep;
        pulse_codec(5, 1'b0);
        @(negedge clk) begin res_sel = 2'b10; alloc_all_pin = 1'b1; end
        idle(3);
        @(negedge clk) pwr_down_req = 1'b1;
        idle(5);
        chk("R7 tri_en off", tri_en, 0);
        chk("R7 hold on", hold, 1);
        // Disturb every frozen source.
        @(negedge clk) begin res_sel = 2'b01; alloc_all_pin = 1'b0; end
        pulse_codec(6, 1'b1);
        chk("R8 mode frozen", mode_decode, 0);
        chk("R8 res frozen", res_bits, 14);
        chk("R8 alloc frozen", alloc_all, 1);
        @(negedge clk) pwr_down_req = 1'b0;
        idle(10);
        chk("R9 no wake on pwr low", hold, 1);
        pulse_sys(3);
        chk("R9 no wake on short reset", hold, 1);
        pulse_sys(5);
        chk("R9 hold cleared", hold, 0);
        chk("R9 tri_en restored", tri_en, 1);
        chk("R9 decode after wake", mode_decode, 1);
        chk("R8 res follows after wake", res_bits, 18);
        chk("R8 alloc follows after wake", alloc_all, 0);
    endtask

    initial begin
        idle(3);
        t_reset_state();
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        t_reset_state();
        t_codec_modes();
        t_codec_short();
        t_sys_reset();
        t_res_table();
        t_alloc();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule